// File: doc/BRIEF.md
# Dual-Side Scratchpad Memory Controller

This controller lets a processor's instruction-fetch side and its data side share one single-port SRAM of 4 KB, organised as 1024 words of 32 bits. Each side has its own 6-bit window register. A request is taken only when the six top address bits of that request equal the window register for its side. Requests outside the window are left for other memory paths and never reach the SRAM.

There are three requesters: a data read channel, a data write channel with four byte enables, and an instruction fetch channel. They compete for the one SRAM port in every cycle under a fixed priority. Data reads win, then data writes, then fetches. A requester that loses holds its request, address and controls stable until its accept pulse arrives.

Data reads return one cycle after acceptance. A write lands in the cycle it is accepted. Fetches return one cycle after acceptance in fast mode, or two cycles after acceptance in slow mode. Slow mode is the default after reset. A small register port reads and writes the two window registers and the mode bit.

Top module: `spm_ctrl`

## Requirements
- R1: While reset is asserted and straight after it, the register port reads the fetch window as 0 at cfg_addr 0, the data window as 0 at cfg_addr 1, and the control word as 1 at cfg_addr 2. In the same period every accept and data-valid output is 0.
- R2: In any cycle at most one of dr_ack, dw_ack and i_ack is high.
- R3: A data read that hits its window is accepted in the cycle it is presented. Its data appears on dr_rdata with dr_rvalid high exactly one cycle later, and dr_rvalid is low in every other cycle.
- R4: A data write that hits its window is accepted, and the SRAM written, in the cycle it is presented. The exception is a cycle in which a data read also hits: the write is then not accepted in that cycle and is accepted in a later cycle free of data reads.
- R5: When bit 0 of the control word is 0 (fast mode), an accepted fetch returns its word on i_rdata with i_rvalid high one cycle after i_ack.
- R6: When bit 0 of the control word is 1 (slow mode), an accepted fetch returns its word two cycles after i_ack. No fetch is accepted in the cycle directly after i_ack. The mode is taken from the cycle in which the fetch is accepted.
- R7: A request on either side counts as a hit only when address bits [31:26] equal that side's window register. Data reads and data writes both use the data window. A request that misses is never accepted and causes no SRAM access.
- R8: The SRAM word address is request address bits [11:2]. A write drives mem_we=1 with the request's byte enables and write data. A read or fetch drives mem_we=0 with mem_be=4'b1111. mem_en is high exactly when a request is accepted.
- R9: Writing through the register port sets the fetch window at cfg_addr 0 (bits [5:0]), the data window at cfg_addr 1 (bits [5:0]), and the mode at cfg_addr 2 (bit 0). cfg_rdata shows the selected register combinationally, reads 0 at cfg_addr 3, and a write affects decoding from the next cycle on.
- R10: A fetch is not accepted in a cycle in which a data read or data write hits its window. It is accepted in a later cycle free of data-side hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Selected register value |
| i_req | input | 1 | Fetch request |
| i_addr | input | 32 | Fetch byte address |
| i_ack | output | 1 | Fetch accepted this cycle |
| i_rvalid | output | 1 | Fetch data valid |
| i_rdata | output | 32 | Fetch data |
| dr_req | input | 1 | Data read request |
| dr_addr | input | 32 | Data read byte address |
| dr_ack | output | 1 | Data read accepted this cycle |
| dr_rvalid | output | 1 | Data read data valid |
| dr_rdata | output | 32 | Data read data |
| dw_req | input | 1 | Data write request |
| dw_addr | input | 32 | Data write byte address |
| dw_be | input | 4 | Data write byte enables |
| dw_wdata | input | 32 | Data write data |
| dw_ack | output | 1 | Data write accepted this cycle |
| mem_en | output | 1 | SRAM access enable |
| mem_we | output | 1 | SRAM write enable |
| mem_be | output | 4 | SRAM byte enables |
| mem_addr | output | 10 | SRAM word address |
| mem_wdata | output | 32 | SRAM write data |
| mem_rdata | input | 32 | SRAM read data, one cycle after a read access |

## Verification
The assertions check several rules on every cycle: one grant at a time, the SRAM enable matching the grant, no grant to a request outside its window, writes and fetches yielding to data-side hits, and the one- and two-cycle return timing in each fetch mode. Other behaviour can only be shown by the bench's scenarios, with its reference memory compared on every clock. That covers the data returned after partial byte-enable writes, the drain order when all three channels fire together in each mode, and window and mode changes taking effect on the next request. It also covers the reset values read back through the register port.

// File: rtl/spm_pkg.sv
package spm_pkg;

  typedef enum logic [1:0] {
    GNT_NONE = 2'd0,
    GNT_DRD  = 2'd1,
    GNT_DWR  = 2'd2,
    GNT_IFT  = 2'd3
  } spm_gnt_e;

  localparam logic [1:0] CFG_IBASE = 2'd0;
  localparam logic [1:0] CFG_DBASE = 2'd1;
  localparam logic [1:0] CFG_CTRL  = 2'd2;

endpackage

// File: rtl/spm_regs.sv
module spm_regs
  import spm_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BASE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [1:0]        cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  output logic [BASE_W-1:0] ibase,
  output logic [BASE_W-1:0] dbase,
  output logic              two_mode
);

  logic [BASE_W-1:0] ibase_d, dbase_d;
  logic              two_d;
  logic              unused_wdata;

  assign unused_wdata = ^cfg_wdata[DATA_W-1:BASE_W];

  always_comb begin
    ibase_d = ibase;
    dbase_d = dbase;
    two_d   = two_mode;
    case (cfg_addr)
      CFG_IBASE: ibase_d = cfg_wdata[BASE_W-1:0];
      CFG_DBASE: dbase_d = cfg_wdata[BASE_W-1:0];
      CFG_CTRL:  two_d   = cfg_wdata[0];
      default:   ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ibase    <= '0;
      dbase    <= '0;
      two_mode <= 1'b1;
    end else if (cfg_wr) begin
      ibase    <= ibase_d;
      dbase    <= dbase_d;
      two_mode <= two_d;
    end
  end

  always_comb begin
    case (cfg_addr)
      CFG_IBASE: cfg_rdata = {{(DATA_W-BASE_W){1'b0}}, ibase};
      CFG_DBASE: cfg_rdata = {{(DATA_W-BASE_W){1'b0}}, dbase};
      CFG_CTRL:  cfg_rdata = {{(DATA_W-1){1'b0}}, two_mode};
      default:   cfg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/spm_arb.sv
module spm_arb
  import spm_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int BASE_W = 6,
  parameter int IDX_W  = 10
) (
  input  logic                i_req,
  input  logic [ADDR_W-1:0]   i_addr,
  input  logic                dr_req,
  input  logic [ADDR_W-1:0]   dr_addr,
  input  logic                dw_req,
  input  logic [ADDR_W-1:0]   dw_addr,
  input  logic [DATA_W/8-1:0] dw_be,
  input  logic [DATA_W-1:0]   dw_wdata,
  input  logic [BASE_W-1:0]   ibase,
  input  logic [BASE_W-1:0]   dbase,
  input  logic                i_block,
  output spm_gnt_e            gnt,
  output logic                mem_en,
  output logic                mem_we,
  output logic [DATA_W/8-1:0] mem_be,
  output logic [IDX_W-1:0]    mem_addr,
  output logic [DATA_W-1:0]   mem_wdata
);

  localparam int BE_W = DATA_W / 8;
  localparam int LSB  = $clog2(BE_W);
  localparam int TOP  = ADDR_W - 1;

  logic i_hit, dr_hit, dw_hit;
  logic unused_addr;

  assign unused_addr = ^{i_addr[TOP-BASE_W:LSB+IDX_W], dr_addr[TOP-BASE_W:LSB+IDX_W],
                         dw_addr[TOP-BASE_W:LSB+IDX_W], i_addr[LSB-1:0],
                         dr_addr[LSB-1:0], dw_addr[LSB-1:0]};

  assign i_hit  = i_req  && (i_addr[TOP -: BASE_W]  == ibase);
  assign dr_hit = dr_req && (dr_addr[TOP -: BASE_W] == dbase);
  assign dw_hit = dw_req && (dw_addr[TOP -: BASE_W] == dbase);

  always_comb begin
    if (dr_hit)                 gnt = GNT_DRD;
    else if (dw_hit)            gnt = GNT_DWR;
    else if (i_hit && !i_block) gnt = GNT_IFT;
    else                        gnt = GNT_NONE;
  end

  always_comb begin
    mem_en    = (gnt != GNT_NONE);
    mem_we    = 1'b0;
    mem_be    = {BE_W{1'b1}};
    mem_wdata = dw_wdata;
    case (gnt)
      GNT_DRD: mem_addr = dr_addr[LSB +: IDX_W];
      GNT_DWR: begin
        mem_addr = dw_addr[LSB +: IDX_W];
        mem_we   = 1'b1;
        mem_be   = dw_be;
      end
      GNT_IFT: mem_addr = i_addr[LSB +: IDX_W];
      default: mem_addr = '0;
    endcase
  end

endmodule

// File: rtl/spm_rdpath.sv
module spm_rdpath
  import spm_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  spm_gnt_e          gnt,
  input  logic              two_mode,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              dr_rvalid,
  output logic [DATA_W-1:0] dr_rdata,
  output logic              i_rvalid,
  output logic [DATA_W-1:0] i_rdata,
  output logic              i_block
);

  logic              drv_q, drv_d;
  logic              f1_q, f1_d;
  logic              f2a_q, f2a_d;
  logic              f2b_q, f2b_d;
  logic [DATA_W-1:0] hold_q;

  always_comb begin
    drv_d = (gnt == GNT_DRD);
    f1_d  = (gnt == GNT_IFT) && !two_mode;
    f2a_d = (gnt == GNT_IFT) &&  two_mode;
    f2b_d = f2a_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drv_q <= 1'b0;
      f1_q  <= 1'b0;
      f2a_q <= 1'b0;
      f2b_q <= 1'b0;
    end else begin
      drv_q <= drv_d;
      f1_q  <= f1_d;
      f2a_q <= f2a_d;
      f2b_q <= f2b_d;
    end
  end

  // Slow-mode fetch data is parked for one extra cycle.
  always_ff @(posedge clk) begin
    if (f2a_q) hold_q <= mem_rdata;
  end

  assign dr_rvalid = drv_q;
  assign dr_rdata  = mem_rdata;
  assign i_rvalid  = f1_q | f2b_q;
  assign i_rdata   = f2b_q ? hold_q : mem_rdata;
  assign i_block   = f2a_q;

endmodule

// File: rtl/spm_ctrl.sv
module spm_ctrl
  import spm_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int BASE_W = 6,
  parameter int IDX_W  = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_wr,
  input  logic [1:0]          cfg_addr,
  input  logic [DATA_W-1:0]   cfg_wdata,
  output logic [DATA_W-1:0]   cfg_rdata,
  input  logic                i_req,
  input  logic [ADDR_W-1:0]   i_addr,
  output logic                i_ack,
  output logic                i_rvalid,
  output logic [DATA_W-1:0]   i_rdata,
  input  logic                dr_req,
  input  logic [ADDR_W-1:0]   dr_addr,
  output logic                dr_ack,
  output logic                dr_rvalid,
  output logic [DATA_W-1:0]   dr_rdata,
  input  logic                dw_req,
  input  logic [ADDR_W-1:0]   dw_addr,
  input  logic [DATA_W/8-1:0] dw_be,
  input  logic [DATA_W-1:0]   dw_wdata,
  output logic                dw_ack,
  output logic                mem_en,
  output logic                mem_we,
  output logic [DATA_W/8-1:0] mem_be,
  output logic [IDX_W-1:0]    mem_addr,
  output logic [DATA_W-1:0]   mem_wdata,
  input  logic [DATA_W-1:0]   mem_rdata
);

  logic [BASE_W-1:0] ibase, dbase;
  logic              two_mode;
  logic              i_block;
  spm_gnt_e          gnt;

  spm_regs #(.DATA_W(DATA_W), .BASE_W(BASE_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .ibase(ibase), .dbase(dbase), .two_mode(two_mode)
  );

  spm_arb #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE_W(BASE_W), .IDX_W(IDX_W)) u_arb (
    .i_req(i_req), .i_addr(i_addr), .dr_req(dr_req), .dr_addr(dr_addr),
    .dw_req(dw_req), .dw_addr(dw_addr), .dw_be(dw_be), .dw_wdata(dw_wdata),
    .ibase(ibase), .dbase(dbase), .i_block(i_block), .gnt(gnt),
    .mem_en(mem_en), .mem_we(mem_we), .mem_be(mem_be),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  spm_rdpath #(.DATA_W(DATA_W)) u_rdpath (
    .clk(clk), .rst_n(rst_n), .gnt(gnt), .two_mode(two_mode),
    .mem_rdata(mem_rdata), .dr_rvalid(dr_rvalid), .dr_rdata(dr_rdata),
    .i_rvalid(i_rvalid), .i_rdata(i_rdata), .i_block(i_block)
  );

  assign dr_ack = (gnt == GNT_DRD);
  assign dw_ack = (gnt == GNT_DWR);
  assign i_ack  = (gnt == GNT_IFT);

endmodule

// File: rtl/spm_ctrl_chk.sv
module spm_ctrl_chk #(
  parameter int ADDR_W = 32,
  parameter int BASE_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              i_req,
  input logic [ADDR_W-1:0] i_addr,
  input logic              dr_req,
  input logic [ADDR_W-1:0] dr_addr,
  input logic              dw_req,
  input logic [ADDR_W-1:0] dw_addr,
  input logic              i_ack,
  input logic              dr_ack,
  input logic              dw_ack,
  input logic              i_rvalid,
  input logic              dr_rvalid,
  input logic              mem_en,
  input logic [BASE_W-1:0] ibase,
  input logic [BASE_W-1:0] dbase,
  input logic              two_mode
);

  localparam int TOP = ADDR_W - 1;

  logic ck_ih, ck_drh, ck_dwh;
  logic unused_low;

  assign unused_low = ^{i_addr[TOP-BASE_W:0], dr_addr[TOP-BASE_W:0], dw_addr[TOP-BASE_W:0]};
  assign ck_ih  = i_req  && (i_addr[TOP -: BASE_W]  == ibase);
  assign ck_drh = dr_req && (dr_addr[TOP -: BASE_W] == dbase);
  assign ck_dwh = dw_req && (dw_addr[TOP -: BASE_W] == dbase);

  a_r2_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dr_ack, dw_ack, i_ack}));

  a_r8_enable_tracks_grant: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en == (dr_ack || dw_ack || i_ack));

  a_r3_read_returns: assert property (@(posedge clk) disable iff (!rst_n)
    dr_ack |=> dr_rvalid);

  a_r3_no_stray_read: assert property (@(posedge clk) disable iff (!rst_n)
    !dr_ack |=> !dr_rvalid);

  a_r4_write_yields: assert property (@(posedge clk) disable iff (!rst_n)
    ck_drh |-> !dw_ack);

  a_r5_fast_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    (i_ack && !two_mode) |=> i_rvalid);

  a_r6_slow_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    (i_ack && two_mode) |=> (!i_rvalid && !i_ack) ##1 i_rvalid);

  a_r7_dread_miss: assert property (@(posedge clk) disable iff (!rst_n)
    !ck_drh |-> !dr_ack);

  a_r7_dwrite_miss: assert property (@(posedge clk) disable iff (!rst_n)
    !ck_dwh |-> !dw_ack);

  a_r7_fetch_miss: assert property (@(posedge clk) disable iff (!rst_n)
    !ck_ih |-> !i_ack);

  a_r10_fetch_yields: assert property (@(posedge clk) disable iff (!rst_n)
    (ck_drh || ck_dwh) |-> !i_ack);

endmodule

bind spm_ctrl spm_ctrl_chk #(.ADDR_W(ADDR_W), .BASE_W(BASE_W)) u_chk (.*);

// File: tb/test_spm_ctrl.sv
module test_spm_ctrl;

  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n;
  logic        cfg_wr;
  logic [1:0]  cfg_addr;
  logic [31:0] cfg_wdata, cfg_rdata;
  logic        i_req, i_ack, i_rvalid;
  logic [31:0] i_addr, i_rdata;
  logic        dr_req, dr_ack, dr_rvalid;
  logic [31:0] dr_addr, dr_rdata;
  logic        dw_req, dw_ack;
  logic [31:0] dw_addr, dw_wdata;
  logic [3:0]  dw_be;
  logic        mem_en, mem_we;
  logic [3:0]  mem_be;
  logic [9:0]  mem_addr;
  logic [31:0] mem_wdata, mem_rdata;

  spm_ctrl i_spm_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .i_req(i_req), .i_addr(i_addr), .i_ack(i_ack), .i_rvalid(i_rvalid), .i_rdata(i_rdata),
    .dr_req(dr_req), .dr_addr(dr_addr), .dr_ack(dr_ack), .dr_rvalid(dr_rvalid),
    .dr_rdata(dr_rdata), .dw_req(dw_req), .dw_addr(dw_addr), .dw_be(dw_be),
    .dw_wdata(dw_wdata), .dw_ack(dw_ack), .mem_en(mem_en), .mem_we(mem_we),
    .mem_be(mem_be), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // SRAM device model on the controller's memory port.
  logic [31:0] dev_mem [0:1023];
  always @(posedge clk) begin
    if (mem_en && mem_we) begin
      for (int b = 0; b < 4; b++)
        if (mem_be[b]) dev_mem[mem_addr][8*b +: 8] <= mem_wdata[8*b +: 8];
    end
    if (mem_en && !mem_we) mem_rdata <= dev_mem[mem_addr];
  end

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // Request queues: {oneshot, valid, addr} and {oneshot, valid, be, data, addr}
  logic [33:0] drq[$], iq[$];
  logic [69:0] dwq[$];
  bit dr_one, dw_one, i_one;
  bit dr_acked, dw_acked, i_acked;

  function automatic logic [31:0] da(input int k);
    return {6'h02, 14'h0, k[9:0], 2'b00};
  endfunction
  function automatic logic [31:0] ia(input int k);
    return {6'h01, 14'h0, k[9:0], 2'b00};
  endfunction

  // Request drivers: hold each request until accepted, oneshot entries last one cycle.
  initial begin
    dr_req = 0; dw_req = 0; i_req = 0; dr_addr = 0; dw_addr = 0; i_addr = 0;
    dw_be = 0; dw_wdata = 0; dr_one = 0; dw_one = 0; i_one = 0;
    forever begin
      @(posedge clk); #1;
      if (!dr_req || dr_acked || dr_one) begin
        if (drq.size() > 0) begin
          logic [33:0] e; e = drq.pop_front();
          dr_req = e[32]; dr_addr = e[31:0]; dr_one = e[33];
        end else begin dr_req = 0; dr_one = 0; end
      end
      if (!dw_req || dw_acked || dw_one) begin
        if (dwq.size() > 0) begin
          logic [69:0] e; e = dwq.pop_front();
          dw_req = e[68]; dw_be = e[67:64]; dw_wdata = e[63:32]; dw_addr = e[31:0]; dw_one = e[69];
        end else begin dw_req = 0; dw_one = 0; end
      end
      if (!i_req || i_acked || i_one) begin
        if (iq.size() > 0) begin
          logic [33:0] e; e = iq.pop_front();
          i_req = e[32]; i_addr = e[31:0]; i_one = e[33];
        end else begin i_req = 0; i_one = 0; end
      end
    end
  end

  // Reference model, evaluated mid-cycle and compared every clock.
  logic [31:0] ref_mem [0:1023];
  logic [5:0]  r_ibase, r_dbase;
  bit          r_two;
  int          cyc, d_due, i_due, blk_cyc;
  logic [31:0] d_data, i_data;
  bit          i_slow;

  initial begin
    for (int k = 0; k < 1024; k++) begin
      ref_mem[k] = k * 32'h9E3779B1;
      dev_mem[k] = k * 32'h9E3779B1;
    end
    cyc = 0; d_due = -1; i_due = -1; blk_cyc = -1;
    forever begin
      @(negedge clk);
      dr_acked = dr_ack; dw_acked = dw_ack; i_acked = i_ack;
      if (!rst_n) begin
        r_ibase = 0; r_dbase = 0; r_two = 1; d_due = -1; i_due = -1; blk_cyc = -1;
      end else if (!finished) begin
        bit drh, dwh, ih, e_dr, e_dw, e_if;
        logic [31:0] e_cfg;
        drh = dr_req && dr_addr[31:26] == r_dbase;
        dwh = dw_req && dw_addr[31:26] == r_dbase;
        ih  = i_req  && i_addr[31:26]  == r_ibase;
        e_dr = drh;
        e_dw = dwh && !drh;
        e_if = ih && !drh && !dwh && (cyc != blk_cyc);
        chk($countones({dr_ack, dw_ack, i_ack}) <= 1, "R2 single grant", {29'b0, dr_ack, dw_ack, i_ack}, 0);
        chk(dr_ack === e_dr, (dr_req && !drh) ? "R7 dr_ack on miss" : "R3 dr_ack", dr_ack, e_dr);
        chk(dw_ack === e_dw, (dw_req && !dwh) ? "R7 dw_ack on miss" : "R4 dw_ack", dw_ack, e_dw);
        chk(i_ack === e_if, (i_req && !ih) ? "R7 i_ack on miss" :
            (ih && (drh || dwh)) ? "R10 i_ack vs data side" :
            (cyc == blk_cyc) ? "R6 i_ack after slow fetch" : "R5 i_ack", i_ack, e_if);
        chk(mem_en === (e_dr || e_dw || e_if), "R8 mem_en", mem_en, e_dr || e_dw || e_if);
        if (e_dw) begin
          chk(mem_we === 1'b1, "R8 mem_we write", mem_we, 1);
          chk(mem_addr === dw_addr[11:2], "R8 write index", mem_addr, dw_addr[11:2]);
          chk(mem_be === dw_be, "R8 write enables", mem_be, dw_be);
          chk(mem_wdata === dw_wdata, "R8 write data", mem_wdata, dw_wdata);
        end else if (e_dr || e_if) begin
          chk(mem_we === 1'b0, "R8 mem_we read", mem_we, 0);
          chk(mem_addr === (e_dr ? dr_addr[11:2] : i_addr[11:2]), "R8 read index",
              mem_addr, e_dr ? dr_addr[11:2] : i_addr[11:2]);
          chk(mem_be === 4'hF, "R8 read enables", mem_be, 4'hF);
        end
        chk(dr_rvalid === (cyc == d_due), "R3 dr_rvalid", dr_rvalid, cyc == d_due);
        if (cyc == d_due) chk(dr_rdata === d_data, "R3 dr_rdata", dr_rdata, d_data);
        chk(i_rvalid === (cyc == i_due), i_slow ? "R6 i_rvalid" : "R5 i_rvalid", i_rvalid, cyc == i_due);
        if (cyc == i_due) chk(i_rdata === i_data, i_slow ? "R6 i_rdata" : "R5 i_rdata", i_rdata, i_data);
        case (cfg_addr)
          2'd0: e_cfg = {26'b0, r_ibase};
          2'd1: e_cfg = {26'b0, r_dbase};
          2'd2: e_cfg = {31'b0, r_two};
          default: e_cfg = 0;
        endcase
        chk(cfg_rdata === e_cfg, "R9 cfg_rdata", cfg_rdata, e_cfg);
        // state for the next cycle
        if (e_dr) begin d_due = cyc + 1; d_data = ref_mem[dr_addr[11:2]]; end
        if (e_dw)
          for (int b = 0; b < 4; b++)
            if (dw_be[b]) ref_mem[dw_addr[11:2]][8*b +: 8] = dw_wdata[8*b +: 8];
        if (e_if) begin
          i_data = ref_mem[i_addr[11:2]];
          i_slow = r_two;
          if (r_two) begin i_due = cyc + 2; blk_cyc = cyc + 1; end
          else i_due = cyc + 1;
        end
        if (cfg_wr) begin
          if (cfg_addr == 2'd0) r_ibase = cfg_wdata[5:0];
          if (cfg_addr == 2'd1) r_dbase = cfg_wdata[5:0];
          if (cfg_addr == 2'd2) r_two   = cfg_wdata[0];
        end
        cyc++;
      end
    end
  end

  task automatic cfg_write(input logic [1:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    cfg_wr = 1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_wr = 0; cfg_addr = 2'd2;
  endtask

  task automatic wait_idle();
    do @(posedge clk);
    while (drq.size() != 0 || dwq.size() != 0 || iq.size() != 0 || dr_req || dw_req || i_req);
    repeat (5) @(posedge clk);
  endtask

  task automatic push_burst(input int base_k, input int n);
    for (int k = 0; k < n; k++) begin
      dwq.push_back({1'b0, 1'b1, 4'hF, 32'hA5000000 + base_k + k, da(base_k + k)});
      drq.push_back({1'b0, 1'b1, da(base_k + n - 1 - k)});
      iq.push_back({1'b0, 1'b1, ia(base_k + k)});
    end
  endtask

  initial begin
    rst_n = 0; cfg_wr = 0; cfg_wdata = 0; cfg_addr = 2'd0;
    #(CLK_PERIOD * 2 + 2);
    // R1: reset values and quiet outputs
    chk(cfg_rdata === 32'd0, "R1 reset fetch window", cfg_rdata, 0);
    cfg_addr = 2'd1; #1;
    chk(cfg_rdata === 32'd0, "R1 reset data window", cfg_rdata, 0);
    cfg_addr = 2'd2; #1;
    chk(cfg_rdata === 32'd1, "R1 reset control word", cfg_rdata, 1);
    chk({dr_ack, dw_ack, i_ack, dr_rvalid, i_rvalid} === 5'b0, "R1 outputs in reset",
        {dr_ack, dw_ack, i_ack, dr_rvalid, i_rvalid}, 0);
    @(negedge clk); rst_n = 1;
    repeat (2) @(posedge clk);

    cfg_write(2'd0, 32'h01);
    cfg_write(2'd1, 32'hFFFF_FF02);
    // slow fetch mode: all three channels at once
    push_burst(16, 8);
    wait_idle();
    // partial byte enables then read-back, mixed with misses on every channel
    dwq.push_back({1'b0, 1'b1, 4'b0101, 32'h11223344, da(40)});
    dwq.push_back({1'b1, 1'b1, 4'hF, 32'hDEADBEEF, {6'h05, 26'h100}});
    dwq.push_back({1'b0, 1'b1, 4'b1000, 32'h99AABBCC, da(40)});
    drq.push_back({1'b0, 1'b0, 32'h0});
    drq.push_back({1'b0, 1'b0, 32'h0});
    drq.push_back({1'b0, 1'b0, 32'h0});
    drq.push_back({1'b1, 1'b1, {6'h07, 26'h40}});
    drq.push_back({1'b0, 1'b1, da(40)});
    iq.push_back({1'b1, 1'b1, da(3)});
    iq.push_back({1'b0, 1'b1, ia(40)});
    wait_idle();
    // window change: old data addresses now miss, new ones hit
    cfg_write(2'd1, 32'h03);
    drq.push_back({1'b1, 1'b1, da(5)});
    drq.push_back({1'b0, 1'b1, {6'h03, 14'h0, 10'd5, 2'b00}});
    wait_idle();
    cfg_write(2'd1, 32'h02);
    // fast fetch mode
    cfg_write(2'd2, 32'h0);
    push_burst(60, 8);
    wait_idle();
    for (int k = 0; k < 6; k++) iq.push_back({1'b0, 1'b1, ia(60 + k)});
    wait_idle();
    // slow mode again: back-to-back fetches are spaced by the block cycle
    cfg_write(2'd2, 32'h1);
    for (int k = 0; k < 6; k++) iq.push_back({1'b0, 1'b1, ia(16 + k)});
    wait_idle();
    // mode flips while fetches stream
    for (int k = 0; k < 10; k++) iq.push_back({1'b0, 1'b1, ia(100 + k)});
    repeat (3) @(posedge clk);
    cfg_write(2'd2, 32'h0);
    cfg_write(2'd2, 32'h1);
    wait_idle();
    cfg_addr = 2'd3;
    repeat (2) @(posedge clk);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule